// File: doc/BRIEF.md
# Two-Point Voltage Hopping Cycle Budget Calculator

This block takes a task's worst-case cycle count and the length of the timeslot the task must fit into. It splits that count into two budgets. One budget covers cycles run at the fast, high-voltage operating point. The other covers cycles run at the slow, low-voltage point. The fast clock is taken to be exactly twice the slow clock. The timeslot is given as a count of slow-clock cycles. Under these two assumptions the fast budget is twice the amount by which the worst case exceeds the timeslot. That takes one subtraction and one shift.

The fast budget is clamped so that it never goes below zero or above the worst case. If even an all-fast schedule cannot meet the timeslot, a flag is raised.

When a task ends early, its controller reports the cycles it did not use, split into slow and fast cycles. The block converts them into slow-cycle time and holds them. The next computation adds that time to its timeslot, so dynamic slack lowers the next fast budget.

A one-cycle start strobe launches a computation. The results are registered and appear on the following cycle with a one-cycle valid strobe.

Top module: `hop_budget_calc`

## Requirements
- R1: During and right after synchronous reset (rst_n low), valid, n_hi, n_lo and infeasible are all 0.
- R2: valid is high for exactly one cycle, in the cycle after each cycle in which start is high, and is low otherwise.
- R3: When valid is high, n_hi + n_lo equals the wcec value presented with start.
- R4: With Tl = slot + carried slack, if Tl >= wcec then n_hi = 0 and n_lo = wcec (all slow).
- R5: If Tl < wcec and 2*(wcec - Tl) <= wcec, then n_hi = 2*(wcec - Tl) and infeasible = 0. Equality (n_lo = 0) counts as feasible.
- R6: If 2*(wcec - Tl) > wcec, then n_hi = wcec, n_lo = 0 and infeasible = 1.
- R7: A cycle with done high adds unused_lo + floor(unused_hi / 2) to the carried slack. The next start then adds that slack to slot.
- R8: A start consumes the carried slack, so a later start sees zero slack unless done arrives in between. If done and start are high in the same cycle, start uses the old slack and the carried slack becomes only the newly reported amount.
- R9: Carried slack saturates at 2^CAR_W - 1 and never wraps.
- R10: In a cycle after one without start, n_hi, n_lo and infeasible keep their values.
- R11: Reset clears the carried slack, so the first start after reset uses slot alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a budget computation |
| wcec | input | CYC_W | Worst-case cycle count of the task |
| slot | input | CYC_W | Timeslot length in slow-clock cycles |
| done | input | 1 | Task finished; unused counts are valid |
| unused_lo | input | CYC_W | Unused slow-clock cycles of the finished task |
| unused_hi | input | CYC_W | Unused fast-clock cycles of the finished task |
| valid | output | 1 | One-cycle strobe qualifying the results |
| n_hi | output | CYC_W | Fast-point cycle budget |
| n_lo | output | CYC_W | Slow-point cycle budget |
| infeasible | output | 1 | Timeslot too short even at all-fast |

## Verification
The bench builds the block with CYC_W = 12 and CAR_W = 8. A slack ceiling of 255 can be reached in a few reports, which exercises the saturation path. Worst-case counts up to 4000 still test wide subtractions against that small carry. The bench's reference model steps through the exact clamp boundaries (Tl = wcec, and Tl = wcec/2 and one below). It also covers a zero-length task, simultaneous start and done, and a reset issued while slack is held.

// File: rtl/hop_pkg.sv
// Package: shared split classification for the hopping budget calculator.
// Assumes: fast clock is exactly twice the slow clock.
package hop_pkg;

    // Which region of the clamp the computed split fell into.
    typedef enum logic [1:0] {
        SPLIT_ALL_LOW  = 2'd0,
        SPLIT_MIXED    = 2'd1,
        SPLIT_ALL_HIGH = 2'd2,
        SPLIT_MISSED   = 2'd3
    } split_kind_e;

endpackage

// File: rtl/hop_slack_acc.sv
// Module: hop_slack_acc
// Holds dynamic slack, in slow-clock cycles, between tasks.
// A report adds unused slow cycles plus half the unused fast cycles.
// A consume strobe empties the store; a report in the same cycle
// refills it with only the new amount. Saturates at 2^CAR_W-1.
// Assumes CAR_W <= CYC_W.
module hop_slack_acc #(
    parameter int CYC_W = 16,
    parameter int CAR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             consume,
    input  logic             report,
    input  logic [CYC_W-1:0] unused_lo,
    input  logic [CYC_W-1:0] unused_hi,
    output logic [CAR_W-1:0] carry
);
    localparam int SUM_W = CYC_W + 2;
    localparam logic [SUM_W-1:0] SAT = SUM_W'({CAR_W{1'b1}});

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] gain;
    logic [SUM_W-1:0] total;
    logic [CAR_W-1:0] carry_d;

    // Form the next slack value, saturating at the register ceiling.
    always_comb begin
        base    = consume ? '0 : SUM_W'(carry);
        gain    = SUM_W'(unused_lo) + SUM_W'(unused_hi >> 1);
        total   = report ? (base + gain) : base;
        carry_d = (total > SAT) ? {CAR_W{1'b1}} : total[CAR_W-1:0];
    end

    // Slack register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) carry <= '0;
        else        carry <= carry_d;
    end
endmodule

// File: rtl/hop_split_core.sv
// Module: hop_split_core
// Combinational split of a worst-case count into fast and slow budgets.
// With fh = 2*fl and timeslot Tl in slow cycles: n_hi = 2*(wcec - Tl),
// clamped to [0, wcec]. Overshoot past wcec is reported as missed.
module hop_split_core
    import hop_pkg::*;
#(
    parameter int CYC_W = 16,
    parameter int CAR_W = 16
) (
    input  logic [CYC_W-1:0] wcec,
    input  logic [CYC_W-1:0] slot,
    input  logic [CAR_W-1:0] carry,
    output logic [CYC_W-1:0] n_hi,
    output logic [CYC_W-1:0] n_lo,
    output split_kind_e      kind
);
    localparam int TL_W = CYC_W + 1;

    logic [TL_W-1:0] tl;
    logic [TL_W-1:0] wx;
    logic [TL_W-1:0] gap;
    logic [TL_W-1:0] dbl;

    // Effective timeslot and doubled shortfall.
    always_comb begin
        tl  = TL_W'(slot) + TL_W'(carry);
        wx  = TL_W'(wcec);
        gap = (tl >= wx) ? '0 : (wx - tl);
        dbl = {gap[CYC_W-1:0], 1'b0};
    end

    // Clamp the fast budget and derive the slow budget from it.
    always_comb begin
        if (tl >= wx) begin
            kind = SPLIT_ALL_LOW;
            n_hi = '0;
        end else if (dbl > wx) begin
            kind = SPLIT_MISSED;
            n_hi = wcec;
        end else if (dbl == wx) begin
            kind = SPLIT_ALL_HIGH;
            n_hi = wcec;
        end else begin
            kind = SPLIT_MIXED;
            n_hi = dbl[CYC_W-1:0];
        end
        n_lo = wcec - n_hi;
    end
endmodule

// File: rtl/hop_result_reg.sv
// Module: hop_result_reg
// Captures a split on start and strobes valid for one cycle.
// Outputs hold between captures.
module hop_result_reg
    import hop_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CYC_W-1:0] n_hi_d,
    input  logic [CYC_W-1:0] n_lo_d,
    input  split_kind_e      kind_d,
    output logic             valid,
    output logic [CYC_W-1:0] n_hi,
    output logic [CYC_W-1:0] n_lo,
    output logic             infeasible
);
    // Result registers with a one-cycle qualifying strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid      <= 1'b0;
            n_hi       <= '0;
            n_lo       <= '0;
            infeasible <= 1'b0;
        end else begin
            valid <= load;
            if (load) begin
                n_hi       <= n_hi_d;
                n_lo       <= n_lo_d;
                infeasible <= (kind_d == SPLIT_MISSED);
            end
        end
    end
endmodule

// File: rtl/hop_budget_calc.sv
// Module: hop_budget_calc (top)
// Splits a task's worst-case cycles between fast and slow operating
// points so the task fits its timeslot. Slack reported after each task
// is carried into the next split. Result one cycle after start.
// Assumes the fast clock runs at twice the slow clock; CAR_W <= CYC_W.
module hop_budget_calc
    import hop_pkg::*;
#(
    parameter int CYC_W = 16,
    parameter int CAR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CYC_W-1:0] wcec,
    input  logic [CYC_W-1:0] slot,
    input  logic             done,
    input  logic [CYC_W-1:0] unused_lo,
    input  logic [CYC_W-1:0] unused_hi,
    output logic             valid,
    output logic [CYC_W-1:0] n_hi,
    output logic [CYC_W-1:0] n_lo,
    output logic             infeasible
);
    logic [CAR_W-1:0] carry;
    logic [CYC_W-1:0] hi_c;
    logic [CYC_W-1:0] lo_c;
    split_kind_e      kind_c;

    hop_slack_acc #(.CYC_W(CYC_W), .CAR_W(CAR_W)) slack_i (
        .clk(clk), .rst_n(rst_n), .consume(start), .report(done),
        .unused_lo(unused_lo), .unused_hi(unused_hi), .carry(carry)
    );

    hop_split_core #(.CYC_W(CYC_W), .CAR_W(CAR_W)) split_i (
        .wcec(wcec), .slot(slot), .carry(carry),
        .n_hi(hi_c), .n_lo(lo_c), .kind(kind_c)
    );

    hop_result_reg #(.CYC_W(CYC_W)) out_i (
        .clk(clk), .rst_n(rst_n), .load(start),
        .n_hi_d(hi_c), .n_lo_d(lo_c), .kind_d(kind_c),
        .valid(valid), .n_hi(n_hi), .n_lo(n_lo), .infeasible(infeasible)
    );
endmodule

// File: rtl/hop_budget_calc_chk.sv
// Module: hop_budget_calc_chk
// Port-level temporal checks for hop_budget_calc, attached by bind.
module hop_budget_calc_chk #(
    parameter int CYC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CYC_W-1:0] wcec,
    input logic [CYC_W-1:0] slot,
    input logic             valid,
    input logic [CYC_W-1:0] n_hi,
    input logic [CYC_W-1:0] n_lo,
    input logic             infeasible
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    assert_valid_caused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(start));

    assert_sum_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((CYC_W+1)'(n_hi) + (CYC_W+1)'(n_lo)) == (CYC_W+1)'($past(wcec)));

    assert_roomy_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ($past(slot) >= $past(wcec))) |-> (n_hi == '0 && !infeasible));

    assert_missed_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && infeasible) |-> (n_lo == '0 && n_hi == $past(wcec)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(n_hi) && $stable(n_lo) && $stable(infeasible)));
endmodule

bind hop_budget_calc hop_budget_calc_chk #(.CYC_W(CYC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wcec(wcec), .slot(slot),
    .valid(valid), .n_hi(n_hi), .n_lo(n_lo), .infeasible(infeasible)
);

// File: tb/hop_budget_calc_tb_top.sv
// Bench: behavioural reference model compared on every falling edge.
module hop_budget_calc_tb_top;
    localparam int CYC_W = 12;
    localparam int CAR_W = 8;
    localparam int CMAX  = (1 << CAR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CYC_W-1:0] wcec = '0;
    logic [CYC_W-1:0] slot = '0;
    logic             done = 1'b0;
    logic [CYC_W-1:0] unused_lo = '0;
    logic [CYC_W-1:0] unused_hi = '0;
    logic             valid;
    logic [CYC_W-1:0] n_hi;
    logic [CYC_W-1:0] n_lo;
    logic             infeasible;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string phase = "R1 reset";

    // Reference model state.
    int m_carry = 0;
    int m_valid = 0;
    int m_hi = 0;
    int m_lo = 0;
    int m_inf = 0;

    always #10 clk = ~clk;

    hop_budget_calc #(.CYC_W(CYC_W), .CAR_W(CAR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wcec(wcec), .slot(slot),
        .done(done), .unused_lo(unused_lo), .unused_hi(unused_hi),
        .valid(valid), .n_hi(n_hi), .n_lo(n_lo), .infeasible(infeasible)
    );

    // Reference model: behavioural, from the requirements.
    always @(posedge clk) begin
        int tl, w, d, base, nxt;
        if (!rst_n) begin
            m_carry = 0; m_valid = 0; m_hi = 0; m_lo = 0; m_inf = 0;
        end else begin
            m_valid = start;
            if (start) begin
                w  = int'(wcec);
                tl = int'(slot) + m_carry;
                if (tl >= w) begin
                    m_hi = 0; m_inf = 0;
                end else begin
                    d = 2 * (w - tl);
                    if (d > w) begin m_hi = w; m_inf = 1; end
                    else begin m_hi = d; m_inf = 0; end
                end
                m_lo = w - m_hi;
            end
            base = start ? 0 : m_carry;
            nxt  = done ? base + int'(unused_lo) + int'(unused_hi) / 2 : base;
            m_carry = (nxt > CMAX) ? CMAX : nxt;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(valid == m_valid[0], "valid strobe (R2)", int'(valid), m_valid);
            chk(int'(n_hi) == m_hi, m_valid != 0 ? "n_hi split (R4/R5/R6)" : "n_hi hold (R10)",
                int'(n_hi), m_hi);
            chk(int'(n_lo) == m_lo, m_valid != 0 ? "n_lo sum (R3)" : "n_lo hold (R10)",
                int'(n_lo), m_lo);
            chk(infeasible == m_inf[0], "infeasible flag (R6)", int'(infeasible), m_inf);
        end
        if (cycles > 50000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic go(input int w, input int s);
        @(negedge clk);
        start = 1'b1; wcec = CYC_W'(w); slot = CYC_W'(s);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic report(input int lo, input int hi);
        @(negedge clk);
        done = 1'b1; unused_lo = CYC_W'(lo); unused_hi = CYC_W'(hi);
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, while reset is held.
        chk(valid == 1'b0 && n_hi == '0 && n_lo == '0 && infeasible == 1'b0,
            "R1 outputs zero in reset", int'(n_hi) + int'(n_lo), 0);
        rst_n = 1'b1;
        phase = "R4 all low";      go(100, 150);
        phase = "R4 Tl equals wcec"; go(100, 100);
        phase = "R4 zero task";    go(0, 0);
        phase = "R5 mixed split";  go(100, 80);
        phase = "R5 equality all high"; go(100, 50);
        phase = "R6 missed by one"; go(100, 49);
        phase = "R6 far short";    go(4000, 0);
        phase = "R2 back to back";
        @(negedge clk); start = 1'b1; wcec = 12'd200; slot = 12'd150;
        @(negedge clk); wcec = 12'd300; slot = 12'd250;
        @(negedge clk); start = 1'b0;
        phase = "R7 slack carried"; report(10, 7); go(100, 80);
        phase = "R8 slack consumed"; go(100, 80);
        phase = "R8 start with done";
        report(20, 0);
        @(negedge clk); start = 1'b1; wcec = 12'd100; slot = 12'd70;
        done = 1'b1; unused_lo = 12'd4; unused_hi = 12'd4;
        @(negedge clk); start = 1'b0; done = 1'b0;
        go(100, 70);
        phase = "R9 saturation";
        for (int i = 0; i < 3; i++) report(200, 100);
        go(4000, 3000);
        phase = "R11 reset clears slack";
        report(30, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(valid == 1'b0 && n_hi == '0, "R1 outputs zero after reset", int'(n_hi), 0);
        rst_n = 1'b1;
        go(100, 80);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule